// File: doc/BRIEF.md
# Debug Pin Mode Controller

This block sets the pad controls for the four shared debug pins of a small device: a combined clock pin, a combined data/mode-select line, test data out and test data in. It tracks whether the port is in JTAG or serial-wire mode, and it drives the input and output enables and the pull controls for each pin. It also reports when the debug link should be treated as lost.

After power-on the port is in JTAG mode. The clock pin and the mode line are live with their pulls on. The two test-data pins stay high-impedance until the TAP tracker reports the first complete instruction update. A watcher on the mode line looks for the switch sequence that moves the port to serial-wire mode. Once that switch happens, only a power-on reset undoes it.

A software pin-enable bit can detach every pin. The link counts as lost only when the pins are detached and no debug power request is active.

Top module: `dbg_pinmode_ctl`

## Requirements
- R1: While `por_n` is low and after it is released, `mode_swd` is 0 and `clk_ie` and `dms_ie` are 1, provided `pin_en` is 1.
- R2: While `pin_en` is 1, the clock pull-down `clk_pd` and the mode-line pull-up `dms_pu` are both 1.
- R3: `tdo_oe`, `tdi_ie` and `tdi_pu` stay 0 from any reset until a `tap_updir` pulse is sampled. A warm reset returns them to 0.
- R4: The cycle after `tap_updir` is sampled high with `pin_en`=1 in JTAG mode, `tdo_oe`, `tdi_ie` and `tdi_pu` are all 1.
- R5: The port switches to serial-wire mode (`mode_swd`=1) in the following case. The mode line, sampled on rising clock edges, must first show at least 50 high samples. Then it must carry the 16-bit value 0xE79E least significant bit first; bit 0 is a 0. Then it must show 50 high samples, and `mode_swd` rises at the edge that samples the 50th one. With only 49 leading highs, 49 trailing highs before a low, or any key bit wrong, the mode does not change.
- R6: `mode_swd` stays 1 through warm resets. Only `por_n` clears it.
- R7: In serial-wire mode, `tdo_oe`, `tdi_ie` and `tdi_pu` are 0, and `tap_updir` has no effect on them.
- R8: With `pin_en`=0, all seven pad controls (`clk_ie`, `clk_pd`, `dms_ie`, `dms_pu`, `tdo_oe`, `tdi_ie`, `tdi_pu`) are 0.
- R9: `link_lost` is 1 exactly when `pin_en` is 0 and every bit of `pwr_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock taken from the clock pin |
| por_n | input | 1 | Power-on reset, active low |
| warm_rst_n | input | 1 | Warm reset, active low; does not clear the mode |
| dms_in | input | 1 | Sampled level of the data/mode-select line |
| tap_updir | input | 1 | Pulse from the TAP tracker: first instruction update after test-logic reset |
| pin_en | input | 1 | Register bit that routes the debug pins |
| pwr_req | input | N_PWRREQ | Debug power request bits |
| clk_ie | output | 1 | Clock pin input enable |
| clk_pd | output | 1 | Clock pin pull-down enable |
| dms_ie | output | 1 | Mode line input enable |
| dms_pu | output | 1 | Mode line pull-up enable |
| tdo_oe | output | 1 | Test data out output enable |
| tdi_ie | output | 1 | Test data in input enable |
| tdi_pu | output | 1 | Test data in pull-up enable |
| mode_swd | output | 1 | 1 when in serial-wire mode |
| link_lost | output | 1 | Debug link considered lost |

## Verification
A wrong watcher state shows at `mode_swd` within one clock of the deciding sample. A miscounted run of highs makes the switch appear one edge early or late. A stale key bit makes a corrupted sequence switch the port, or a correct one fail to. A wrong enable flag shows on the three test-data controls one cycle after the arming pulse or after a warm reset. A lost sticky bit shows after the first warm reset in serial-wire mode.

// File: rtl/dbg_pinmode_ctl.sv
module dbg_pinmode_ctl #(
  parameter int HIGH_MIN = 50,
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] SEL_KEY = 16'hE79E,
  parameter int N_PWRREQ = 2
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                warm_rst_n,
  input  logic                dms_in,
  input  logic                tap_updir,
  input  logic                pin_en,
  input  logic [N_PWRREQ-1:0] pwr_req,
  output logic                clk_ie,
  output logic                clk_pd,
  output logic                dms_ie,
  output logic                dms_pu,
  output logic                tdo_oe,
  output logic                tdi_ie,
  output logic                tdi_pu,
  output logic                mode_swd,
  output logic                link_lost
);

  localparam int CW = $clog2(HIGH_MIN + 1);
  localparam int BW = $clog2(KEY_W);

  typedef enum logic [1:0] {LEAD, KEYIN, TRAIL} det_t;

  logic rst_n;
  assign rst_n = por_n & warm_rst_n;

  det_t             st;
  logic [CW-1:0]    hicnt;
  logic [BW-1:0]    bitn;
  logic [KEY_W-1:0] shreg;
  logic [KEY_W-1:0] shnext;
  logic             armed;
  logic             watch;
  logic             swd_set;

  assign watch   = pin_en & ~mode_swd;
  assign shnext  = {dms_in, shreg[KEY_W-1:1]};
  assign swd_set = watch & (st == TRAIL) & dms_in & (hicnt == CW'(HIGH_MIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= LEAD;
      hicnt <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else if (watch) begin
      case (st)
        LEAD: begin
          if (dms_in) begin
            if (hicnt != CW'(HIGH_MIN)) hicnt <= hicnt + 1'b1;
          end else if (hicnt == CW'(HIGH_MIN)) begin
            st    <= KEYIN;
            shreg <= shnext;
            bitn  <= BW'(1);
            hicnt <= '0;
          end else begin
            hicnt <= '0;
          end
        end
        KEYIN: begin
          shreg <= shnext;
          bitn  <= bitn + 1'b1;
          if (bitn == BW'(KEY_W - 1)) begin
            hicnt <= '0;
            if (shnext == SEL_KEY) st <= TRAIL;
            else begin
              st    <= LEAD;
              hicnt <= CW'(dms_in);
            end
          end
        end
        TRAIL: begin
          if (!dms_in) begin
            st    <= LEAD;
            hicnt <= '0;
          end else if (swd_set) begin
            st    <= LEAD;
            hicnt <= '0;
          end else begin
            hicnt <= hicnt + 1'b1;
          end
        end
        default: st <= LEAD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) mode_swd <= 1'b0;
    else if (swd_set) mode_swd <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (tap_updir & watch) armed <= 1'b1;
  end

  logic jt_live;
  assign jt_live = pin_en & armed & ~mode_swd;

  assign clk_ie    = pin_en;
  assign clk_pd    = pin_en;
  assign dms_ie    = pin_en;
  assign dms_pu    = pin_en;
  assign tdo_oe    = jt_live;
  assign tdi_ie    = jt_live;
  assign tdi_pu    = jt_live;
  assign link_lost = ~pin_en & ~(|pwr_req);

  assert_arm_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(tap_updir));

  assert_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!tdo_oe && !tdi_ie && !tdi_pu));

  assert_arm_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_updir && pin_en && !mode_swd) |=> (tdi_pu || !pin_en || mode_swd));

  assert_switch_high_R5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(mode_swd) |-> $past(dms_in));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
    mode_swd |=> mode_swd);

  assert_swd_ignore_R7: assert property (@(posedge clk) disable iff (!por_n)
    (mode_swd && tap_updir) |=> !tdi_pu && !tdo_oe);

endmodule

// File: tb/dbg_pinmode_ctl_tb.sv
module dbg_pinmode_ctl_tb_top;
  localparam logic [15:0] KEY = 16'hE79E;

  logic clk = 1'b0;
  logic por_n = 1'b0, warm_rst_n = 1'b1, dms_in = 1'b0, tap_updir = 1'b0, pin_en = 1'b1;
  logic [1:0] pwr_req = 2'b00;
  logic clk_ie, clk_pd, dms_ie, dms_pu, tdo_oe, tdi_ie, tdi_pu, mode_swd, link_lost;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dbg_pinmode_ctl dut_i (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .dms_in(dms_in),
    .tap_updir(tap_updir), .pin_en(pin_en), .pwr_req(pwr_req),
    .clk_ie(clk_ie), .clk_pd(clk_pd), .dms_ie(dms_ie), .dms_pu(dms_pu),
    .tdo_oe(tdo_oe), .tdi_ie(tdi_ie), .tdi_pu(tdi_pu),
    .mode_swd(mode_swd), .link_lost(link_lost));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic b);
    dms_in = b;
    @(negedge clk);
  endtask

  task automatic highs(input int n);
    for (int i = 0; i < n; i++) tick(1'b1);
  endtask

  task automatic send_key(input logic [15:0] k);
    for (int i = 0; i < 16; i++) tick(k[i]);
  endtask

  task automatic do_por;
    dms_in = 1'b0;
    tap_updir = 1'b0;
    por_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_updir;
    tap_updir = 1'b1;
    @(negedge clk);
    tap_updir = 1'b0;
  endtask

  task automatic chk_td(input string req, input logic exp);
    chk(req, tdo_oe, exp);
    chk(req, tdi_ie, exp);
    chk(req, tdi_pu, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 mode in reset", mode_swd, 1'b0);
    do_por;
    chk("R1 mode", mode_swd, 1'b0);
    chk("R1 clk_ie", clk_ie, 1'b1);
    chk("R1 dms_ie", dms_ie, 1'b1);
    chk("R2 clk_pd", clk_pd, 1'b1);
    chk("R2 dms_pu", dms_pu, 1'b1);
    chk_td("R3 hidden after por", 1'b0);
    tick(1'b0);
    chk_td("R3 still hidden", 1'b0);

    pulse_updir;
    chk_td("R4 armed", 1'b1);
    warm_rst_n = 1'b0;
    @(negedge clk);
    warm_rst_n = 1'b1;
    @(negedge clk);
    chk_td("R3 hidden after warm reset", 1'b0);

    // R9 and R8: exhaustive sweep over pin_en x pwr_req
    for (int pe = 0; pe < 2; pe++) begin
      for (int pr = 0; pr < 4; pr++) begin
        pin_en = pe[0];
        pwr_req = pr[1:0];
        #1;
        chk("R9 link_lost", link_lost, (pe == 0 && pr == 0));
        chk("R8 clk_ie", clk_ie, pe[0]);
        chk("R8 dms_pu", dms_pu, pe[0]);
      end
    end
    pin_en = 1'b0;
    pulse_updir;
    chk_td("R8 td off while detached", 1'b0);
    chk("R8 clk_pd", clk_pd, 1'b0);
    chk("R8 dms_ie", dms_ie, 1'b0);
    pin_en = 1'b1;
    pwr_req = 2'b00;

    // R5 leading count sweep
    for (int lead = 49; lead <= 50; lead++) begin
      do_por;
      highs(lead);
      send_key(KEY);
      highs(50);
      chk("R5 lead count", mode_swd, (lead >= 50));
    end

    // R5 trailing count: 49 highs then low
    do_por;
    highs(50); send_key(KEY); highs(49); tick(1'b0);
    chk("R5 trailing 49", mode_swd, 1'b0);

    // R5 single-bit key corruption sweep
    do_por;
    for (int b = 0; b < 16; b++) begin
      highs(50);
      send_key(KEY ^ (16'h1 << b));
      highs(50);
      tick(1'b0);
      chk("R5 corrupted key", mode_swd, 1'b0);
    end

    // R5 exact switch edge
    do_por;
    pulse_updir;
    chk_td("R4 armed before switch", 1'b1);
    highs(50); send_key(KEY); highs(49);
    chk("R5 before 50th trailing", mode_swd, 1'b0);
    highs(1);
    chk("R5 at 50th trailing", mode_swd, 1'b1);
    chk_td("R7 td off in swd", 1'b0);
    pulse_updir;
    tick(1'b0);
    chk_td("R7 updir ignored", 1'b0);
    chk("R2 clk_pd in swd", clk_pd, 1'b1);

    warm_rst_n = 1'b0;
    @(negedge clk);
    chk("R6 during warm reset", mode_swd, 1'b1);
    warm_rst_n = 1'b1;
    @(negedge clk);
    chk("R6 after warm reset", mode_swd, 1'b1);
    do_por;
    chk("R6 cleared by por", mode_swd, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule